// File: doc/BRIEF.md
# Scatter-Gather Offset Locator

This block walks a scatter-gather descriptor table held in memory. A start pulse carries the options word of a command header, the base address of the command table and a byte offset into the transfer. The block takes the entry count from the options word. It reads descriptors one at a time and finds the descriptor that holds the requested offset. It then streams out a list of (address, length) segments. The segment list begins at that offset and runs to the end of the table.

The first segment is trimmed so that it begins exactly at the offset. Every later descriptor is passed through whole. Each descriptor stores its size zero-based, so the block adds one to each stored size. A zero entry count is reported as an error, and so is an offset that lies past the sum of all descriptor sizes. The block fetches no payload data and translates no addresses.

Top module: `sg_offset_locator`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. The entry count is taken from bits 31:16 of `opts`. A start pulse while `busy` is high has no effect on the run in progress.
- R2: Descriptor i is read from address `tbl_base + 0x80 + 16*i`, in increasing i. The read data arrives on `rd_data` one cycle after `rd_en`.
- R3: In `rd_data`, bits 63:0 hold the segment address and bits 95:64 are reserved. Bits 117:96 hold the zero-based size, so the descriptor covers size+1 bytes. Bits 127:118 are flags and do not change any result.
- R4: A zero entry count ends the run with `done` and `err` both high in the cycle after start. No read is issued and no segment is emitted.
- R5: The first emitted descriptor is the lowest index i for which offset <= S_i + bytes_i. Here S_i is the sum of byte counts of descriptors 0..i-1, kept as a 32-bit running sum.
- R6: The first segment is (addr_i + p, bytes_i - p), where p = offset - S_i. It has zero length when the offset falls exactly on the end of the descriptor.
- R7: Every descriptor after the first is emitted as (address, bytes) in index order. `seg_last` is high only on the segment from descriptor count-1.
- R8: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` hold their values.
- R9: If no descriptor meets the R5 condition, the run ends with `err` high. All count descriptors are read first, and no segment is emitted.
- R10: `done` is a single-cycle pulse that ends every accepted run, and `busy` is low in the next cycle. `err` can be high only together with `done`, and it is low after a successful run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted when idle) |
| opts | input | 32 | Command header options word; entry count in bits 31:16 |
| tbl_base | input | 64 | Command table base address |
| offset | input | 32 | Starting byte offset into the transfer |
| busy | output | 1 | A run is in progress |
| rd_en | output | 1 | Descriptor read request |
| rd_addr | output | 64 | Descriptor byte address |
| rd_data | input | 128 | Descriptor returned one cycle after rd_en |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts segment |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 32 | Segment length in bytes |
| seg_last | output | 1 | Final segment of the list |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run failed (valid with done) |

## Verification
The hardest case to reach is the offset that lands exactly on the end of a descriptor. There the inclusive comparison must select that descriptor and emit a zero-length first segment rather than move on to the next one. The bench therefore sweeps every offset from zero to one byte past the table total for several small tables. This covers every boundary, the zero-length case and the overrun error. A further table has a near-maximum 22-bit size with flag bits set, to exercise the size masking and the wide running sum. Consumer back-pressure follows a changing pattern throughout the sweep. One run also pulses start in the middle of the search, with a zero count, to show that the second start has no effect.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

    localparam int ADDR_W  = 64;
    localparam int LEN_W   = 32;
    localparam int CNT_W   = 16;
    localparam int SIZE_W  = 22;
    localparam int SIZE_LO = 96;
    localparam int ENT_W   = 128;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_EVAL,
        ST_OUT,
        ST_DONE
    } sgl_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
    } sgl_seg_t;

    // Byte count covered by a descriptor: stored size is zero-based.
    function automatic logic [LEN_W-1:0] ent_bytes(input logic [ENT_W-1:0] e);
        return LEN_W'(e[SIZE_LO +: SIZE_W]) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/sgl_addr_gen.sv
module sgl_addr_gen #(
    parameter int AW        = 64,
    parameter int IW        = 16,
    parameter int TBL_OFS   = 128,
    parameter int ENT_BYTES = 16
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int ENT_SH = $clog2(ENT_BYTES);

    always_comb begin
        addr = base + AW'(TBL_OFS) + (AW'(idx) << ENT_SH);
    end
endmodule

// File: rtl/sgl_entry_eval.sv
module sgl_entry_eval
    import sgl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W,
    parameter int EW = ENT_W
) (
    input  logic [EW-1:0] entry,
    input  logic [LW-1:0] run_sum,
    input  logic [LW-1:0] ofs,
    output logic          hit,
    output logic [LW-1:0] next_sum,
    output logic [AW-1:0] trim_addr,
    output logic [LW-1:0] trim_len,
    output logic [AW-1:0] whole_addr,
    output logic [LW-1:0] whole_len
);
    localparam int SW = LW + 1;

    logic [LW-1:0] bytes;
    logic [SW-1:0] limit;
    logic [LW-1:0] pos;

    always_comb begin
        bytes      = ent_bytes(entry);
        limit      = SW'(run_sum) + SW'(bytes);
        hit        = SW'(ofs) <= limit;
        next_sum   = run_sum + bytes;
        pos        = ofs - run_sum;
        whole_addr = entry[AW-1:0];
        whole_len  = bytes;
        trim_addr  = entry[AW-1:0] + AW'(pos);
        trim_len   = bytes - pos;
    end
endmodule

// File: rtl/sg_offset_locator.sv
module sg_offset_locator
    import sgl_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int LW        = LEN_W,
    parameter int CW        = CNT_W,
    parameter int EW        = ENT_W,
    parameter int OPTS_W    = 32,
    parameter int TBL_OFS   = 128,
    parameter int ENT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPTS_W-1:0] opts,
    input  logic [AW-1:0]     tbl_base,
    input  logic [LW-1:0]     offset,
    output logic              busy,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [EW-1:0]     rd_data,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [AW-1:0]     seg_addr,
    output logic [LW-1:0]     seg_len,
    output logic              seg_last,
    output logic              done,
    output logic              err
);
    sgl_state_t    state;
    logic [CW-1:0] cnt_q, idx_q;
    logic [LW-1:0] sum_q, ofs_q;
    logic [AW-1:0] base_q;
    logic          found_q, err_q;
    sgl_seg_t      seg_q;

    logic          hit;
    logic [LW-1:0] next_sum, trim_len, whole_len;
    logic [AW-1:0] trim_addr, whole_addr;
    logic          at_end;

    sgl_addr_gen #(
        .AW(AW), .IW(CW), .TBL_OFS(TBL_OFS), .ENT_BYTES(ENT_BYTES)
    ) addr_i (
        .base(base_q), .idx(idx_q), .addr(rd_addr)
    );

    sgl_entry_eval #(.AW(AW), .LW(LW), .EW(EW)) eval_i (
        .entry(rd_data), .run_sum(sum_q), .ofs(ofs_q),
        .hit(hit), .next_sum(next_sum),
        .trim_addr(trim_addr), .trim_len(trim_len),
        .whole_addr(whole_addr), .whole_len(whole_len)
    );

    assign at_end    = (idx_q == cnt_q - CW'(1));
    assign busy      = (state != ST_IDLE);
    assign rd_en     = (state == ST_RD);
    assign seg_valid = (state == ST_OUT);
    assign seg_addr  = seg_q.addr;
    assign seg_len   = seg_q.len;
    assign seg_last  = seg_q.last;
    assign done      = (state == ST_DONE);
    assign err       = (state == ST_DONE) && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            ofs_q   <= '0;
            base_q  <= '0;
            found_q <= 1'b0;
            err_q   <= 1'b0;
            seg_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= opts[OPTS_W-1 -: CW];
                        idx_q   <= '0;
                        sum_q   <= '0;
                        ofs_q   <= offset;
                        base_q  <= tbl_base;
                        found_q <= 1'b0;
                        if (opts[OPTS_W-1 -: CW] == '0) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            err_q <= 1'b0;
                            state <= ST_RD;
                        end
                    end
                end
                ST_RD: state <= ST_EVAL;
                ST_EVAL: begin
                    if (found_q) begin
                        seg_q <= '{addr: whole_addr, len: whole_len, last: at_end};
                        state <= ST_OUT;
                    end else if (hit) begin
                        found_q <= 1'b1;
                        seg_q   <= '{addr: trim_addr, len: trim_len, last: at_end};
                        state   <= ST_OUT;
                    end else if (at_end) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        sum_q <= next_sum;
                        idx_q <= idx_q + CW'(1);
                        state <= ST_RD;
                    end
                end
                ST_OUT: begin
                    if (seg_ready) begin
                        if (seg_q.last) begin
                            state <= ST_DONE;
                        end else begin
                            idx_q <= idx_q + CW'(1);
                            state <= ST_RD;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgl_locator_chk.sv
module sgl_locator_chk #(
    parameter int AW     = 64,
    parameter int LW     = 32,
    parameter int OPTS_W = 32,
    parameter int CW     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OPTS_W-1:0] opts,
    input logic              busy,
    input logic              rd_en,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [AW-1:0]     seg_addr,
    input logic [LW-1:0]     seg_len,
    input logic              seg_last,
    input logic              done,
    input logic              err
);
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr)
            && $stable(seg_len) && $stable(seg_last));

    a_r4_zero_count: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (opts[OPTS_W-1 -: CW] == '0) |=> done && err && !rd_en);

    a_r10_done_ends: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r1_start_taken: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    a_r2_read_in_run: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy && !seg_valid && !done);
endmodule

bind sg_offset_locator sgl_locator_chk #(
    .AW(AW), .LW(LW), .OPTS_W(OPTS_W), .CW(CW)
) chk_i (
    .clk(clk), .rst(rst), .start(start), .opts(opts), .busy(busy),
    .rd_en(rd_en), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .done(done), .err(err)
);

// File: tb/sg_offset_locator_tb.sv
module sg_offset_locator_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [31:0]  opts = '0;
    logic [63:0]  tbl_base = '0;
    logic [31:0]  offset = '0;
    logic         busy, rd_en, seg_valid, seg_last, done, err;
    logic [63:0]  rd_addr, seg_addr;
    logic [127:0] rd_data = '0;
    logic         seg_ready = 1'b0;
    logic [31:0]  seg_len;

    int checks = 0;
    int failures = 0;
    int run_no = 0;
    int cur_cnt = 0;

    logic [63:0] e_addr [8];
    logic [21:0] e_size [8];
    logic [9:0]  e_flag [8];

    logic [63:0] x_addr [8];
    logic [31:0] x_len  [8];
    logic        x_last [8];
    int          x_n;
    logic        x_err;

    always #10 clk = ~clk;

    sg_offset_locator dut_i (
        .clk(clk), .rst(rst), .start(start), .opts(opts), .tbl_base(tbl_base),
        .offset(offset), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .done(done), .err(err)
    );

    // Descriptor memory model, one-cycle read latency.
    always @(posedge clk) begin
        if (rd_en) begin
            logic [63:0] rel;
            int k;
            rel = rd_addr - tbl_base - 64'h80;
            k = int'(rel[6:4]);
            rd_data <= {e_flag[k], e_size[k], 32'hC0DE_F00D, e_addr[k]};
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s run=%0d actual=%h expected=%h", req, run_no, act, exp);
        end
    endtask

    task automatic build_expect(input int cnt, input logic [31:0] ofs);
        logic [32:0] sum;
        int first;
        sum = '0;
        first = -1;
        x_n = 0;
        for (int i = 0; i < cnt; i++) begin
            logic [32:0] b;
            b = 33'(e_size[i]) + 33'd1;
            if (first < 0 && 33'(ofs) <= sum + b) begin
                logic [31:0] p;
                first = i;
                p = ofs - sum[31:0];
                x_addr[0] = e_addr[i] + 64'(p);
                x_len[0]  = b[31:0] - p;
                x_last[0] = (i == cnt - 1);
                x_n = 1;
            end else if (first >= 0) begin
                x_addr[x_n] = e_addr[i];
                x_len[x_n]  = b[31:0];
                x_last[x_n] = (i == cnt - 1);
                x_n++;
            end else begin
                sum = sum + b;
            end
        end
        x_err = (first < 0);
    endtask

    task automatic run(input int cnt, input logic [31:0] ofs, input bit poke);
        int got;
        int reads;
        bit fin;
        run_no++;
        cur_cnt = cnt;
        build_expect(cnt, ofs);
        got = 0;
        reads = 0;
        fin = 0;
        tbl_base = 64'h0000_0034_5600_0000 + 64'(run_no) * 64'h1000;
        @(negedge clk);
        start  = 1'b1;
        opts   = {16'(cnt), 16'h5A5A};
        offset = ofs;
        for (int c = 0; c < 400 && !fin; c++) begin
            @(negedge clk);
            if (poke && c == 1) begin
                start = 1'b1;
                opts = 32'h0000_1234;
                offset = 32'd0;
            end else begin
                start = 1'b0;
            end
            seg_ready = ((c * 3 + run_no) % 4) != 0;
            if (rd_en) begin
                logic [63:0] rel;
                rel = rd_addr - tbl_base - 64'h80;
                chk(rel[3:0] == 4'd0 && rel[63:4] == 60'(reads), "R2 read address",
                    rd_addr, tbl_base + 64'h80 + 64'(reads) * 64'd16);
                reads++;
            end
            if (seg_valid && seg_ready) begin
                if (got < x_n) begin
                    chk(seg_addr == x_addr[got], got == 0 ? "R6 first seg addr" : "R7 seg addr",
                        seg_addr, x_addr[got]);
                    chk(seg_len == x_len[got], got == 0 ? "R5 first seg len" : "R7 seg len",
                        64'(seg_len), 64'(x_len[got]));
                    chk(seg_last == x_last[got], "R7 last flag", 64'(seg_last), 64'(x_last[got]));
                end else begin
                    chk(1'b0, "R9 unexpected segment", seg_addr, 64'd0);
                end
                got++;
            end
            if (done) begin
                fin = 1;
                chk(err == x_err, "R10 error flag", 64'(err), 64'(x_err));
                chk(got == x_n, "R5 segment count", 64'(got), 64'(x_n));
                if (cnt == 0) chk(reads == 0, "R4 reads on zero count", 64'(reads), 64'd0);
                if (x_err && cnt > 0) chk(reads == cnt, "R9 reads before error", 64'(reads), 64'(cnt));
            end
        end
        if (!fin) chk(1'b0, "R10 run did not finish", 64'd0, 64'd1);
        @(negedge clk);
        chk(!busy && !err, "R10 idle after done", 64'(busy), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired run=%0d", run_no);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !seg_valid && !done && !rd_en && !err, "R10 reset state",
            {59'd0, busy, seg_valid, done, rd_en, err}, 64'd0);

        // Zero count
        for (int i = 0; i < 8; i++) begin
            e_addr[i] = 64'h0000_00AB_0000_0000 + 64'(i) * 64'h0110_0000;
            e_size[i] = 22'd3;
            e_flag[i] = 10'h3FF;
        end
        run(0, 32'd0, 1'b0);
        run(0, 32'd17, 1'b0);

        // Small tables, every offset up to one past the total (R5, R6, R7, R9, R3 flags)
        for (int cfg = 1; cfg <= 4; cfg++) begin
            int total;
            total = 0;
            for (int i = 0; i < 8; i++) begin
                e_size[i] = 22'(((cfg * 5) + i * 3) % 7);
                e_flag[i] = 10'(cfg * 97 + i * 31);
                e_addr[i] = 64'h0000_0F00_0000_1000 * 64'(cfg) + 64'(i) * 64'h40;
            end
            for (int i = 0; i < cfg; i++) total += int'(e_size[i]) + 1;
            for (int o = 0; o <= total + 1; o++) run(cfg, 32'(o), 1'b0);
        end

        // R1: start pulse mid-run with zero count must be ignored
        run(3, 32'd2, 1'b1);
        run(4, 32'd9, 1'b1);

        // R3: full-width size field, flags set
        e_size[0] = 22'd3;
        e_size[1] = 22'h3FFFFF;
        e_size[2] = 22'd7;
        for (int i = 0; i < 3; i++) e_flag[i] = 10'h2AA;
        run(3, 32'd0, 1'b0);
        run(3, 32'd5, 1'b0);
        run(3, 32'h0040_0004, 1'b0);
        run(3, 32'h0040_0005, 1'b0);
        run(3, 32'h0040_000C, 1'b0);
        run(3, 32'h0040_000D, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule